// File: doc/BRIEF.md
# Trigger Latency Pipeline with Derandomizing Event Queue

This block stands between a detector channel group and its readout. Every beam-crossing clock it takes one multi-bit sample word and writes it into a circular latency buffer that is one cell per crossing. The buffer is deep enough to hold samples for the whole time the first-level trigger needs to decide. When a trigger accept arrives, the block looks back a fixed number of crossings to find the triggered crossing. It takes that cell and the cell on each side of it as one event.

Each event goes, in a single clock, into a small derandomizing queue of whole events. The queue absorbs triggers that arrive at random times. A slower readout side empties it one word per valid/ready handshake, and the third word of each event carries an end-of-event flag. A trigger that finds the queue full is lost. The loss is recorded in a sticky overflow flag and a saturating drop counter.

Top module: `trig_latency_derand`

## Requirements
- R1: After a synchronous reset, the queue is empty, `q_full` is 0, `rd_valid` is 0, `overflow` is 0 and `drop_count` is 0.
- R2: The sample present at each clock edge out of reset is stored in the next ring cell. The write position wraps from cell DEPTH-1 back to cell 0, so samples stay retrievable across the wrap.
- R3: A trigger at the edge where crossing n is written yields an event of three words. In order, they are the samples of crossings n-LATENCY-1, n-LATENCY and n-LATENCY+1, counted in crossings since reset.
- R4: `rd_last` is 1 on the third word of each event only, and never while `rd_valid` is 0.
- R5: While `rd_valid` is 1 and `rd_ready` is 0, `rd_data`, `rd_last` and `rd_valid` hold. Each edge with both high advances the readout by exactly one word.
- R6: The queue holds up to 8 events. `q_full` is 1 when 8 events are held, and `q_empty` is 1 when none are held.
- R7: A trigger at an edge where the queue is full is dropped and the held events are unchanged. `overflow` becomes 1 and stays 1 until reset, and `drop_count` rises by one, saturating at its maximum.
- R8: Triggers on consecutive clocks each produce their own event while space remains.
- R9: Events are read out in the order their triggers arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | DATA_W | Sample word of the current crossing |
| trig_in | input | 1 | First-level trigger accept for this edge |
| rd_ready | input | 1 | Readout side accepts a word |
| rd_valid | output | 1 | A word is offered |
| rd_data | output | DATA_W | Offered word |
| rd_last | output | 1 | Offered word ends its event |
| q_full | output | 1 | Queue holds the maximum number of events |
| q_empty | output | 1 | Queue holds no event |
| overflow | output | 1 | Sticky: at least one trigger was dropped |
| drop_count | output | DROP_W | Saturating count of dropped triggers |

## Verification
The bench drives the crossing number as the sample, so each event word identifies the crossing it came from. It places one trigger so that its three cells straddle the ring's wrap point. An off-by-one or a missed modulo there would return stale or neighbouring crossings. It fires triggers on adjacent clocks and then fills the queue to capacity before sending one more. A design that drops either of two back-to-back triggers, reorders events, overwrites a held event or lets the overflow flag fall again is caught by the drained word values. Holding `rd_ready` low confirms that a stalled word does not advance or change.

// File: rtl/trig_pipe_pkg.sv
package trig_pipe_pkg;

   // Reduce a value known to lie in [0, 2*modulus) into [0, modulus).
   function automatic int ring_wrap(input int value, input int modulus);
      return (value >= modulus) ? value - modulus : value;
   endfunction

endpackage

// File: rtl/latency_ring.sv
module latency_ring
   import trig_pipe_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 132,
   parameter int LATENCY = 100,
   parameter int WIN     = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [DATA_W-1:0]       sample_in,
   output logic [WIN*DATA_W-1:0]   win_data
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int HALF  = (WIN - 1) / 2;

   initial begin : chk_params
      assert (WIN >= 1) else $fatal(1, "window must hold at least one word");
      assert (LATENCY >= WIN - HALF) else $fatal(1, "newest window cell would be unwritten");
      assert (LATENCY + HALF < DEPTH) else $fatal(1, "oldest window cell would be overwritten");
   end

   logic [DATA_W-1:0] cells_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr_q <= '0;
      end else begin
         wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst) begin
         cells_q[wr_ptr_q] <= sample_in;
      end
   end

   // One read tap per window word; tap k is (LATENCY + HALF - k) cells behind the write slot.
   for (genvar k = 0; k < WIN; k++) begin : g_tap
      localparam int AHEAD = DEPTH - LATENCY - HALF + k;
      logic [PTR_W-1:0] tap_idx;
      assign tap_idx = PTR_W'(ring_wrap(int'(wr_ptr_q) + AHEAD, DEPTH));
      assign win_data[k*DATA_W +: DATA_W] = cells_q[tap_idx];
   end

   // R2: the write position never leaves the ring and wraps to cell 0.
   assert_ptr_range_R2: assert property (@(posedge clk) disable iff (rst)
      wr_ptr_q < PTR_W'(DEPTH));
   assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (rst)
      (wr_ptr_q == PTR_W'(DEPTH - 1)) |=> (wr_ptr_q == '0));

endmodule

// File: rtl/event_queue.sv
module event_queue #(
   parameter int EVT_W  = 48,
   parameter int SLOTS  = 8,
   parameter int DROP_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push,
   input  logic [EVT_W-1:0]  push_data,
   input  logic              pop,
   output logic [EVT_W-1:0]  head_data,
   output logic              full,
   output logic              empty,
   output logic              overflow,
   output logic [DROP_W-1:0] drop_cnt
);
   localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
   localparam int CNT_W = $clog2(SLOTS + 1);

   initial begin : chk_params
      assert (SLOTS >= 1) else $fatal(1, "queue needs at least one slot");
      assert (DROP_W >= 1) else $fatal(1, "drop counter needs a bit");
   end

   logic [EVT_W-1:0]  slots_q [SLOTS];
   logic [PTR_W-1:0]  wr_idx_q, rd_idx_q;
   logic [CNT_W-1:0]  count_q;
   logic              overflow_q;
   logic [DROP_W-1:0] drop_q;
   logic              accept, take;

   assign full     = (count_q == CNT_W'(SLOTS));
   assign empty    = (count_q == '0);
   assign accept   = push && !full;
   assign take     = pop && !empty;
   assign head_data = slots_q[rd_idx_q];
   assign overflow = overflow_q;
   assign drop_cnt = drop_q;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] idx);
      return (idx == PTR_W'(SLOTS - 1)) ? '0 : idx + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_idx_q <= '0;
         rd_idx_q <= '0;
         count_q  <= '0;
      end else begin
         if (accept) wr_idx_q <= step(wr_idx_q);
         if (take)   rd_idx_q <= step(rd_idx_q);
         case ({accept, take})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst && accept) begin
         slots_q[wr_idx_q] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         overflow_q <= 1'b0;
         drop_q     <= '0;
      end else if (push && full) begin
         overflow_q <= 1'b1;
         if (drop_q != '1) drop_q <= drop_q + 1'b1;
      end
   end

   assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
      count_q <= CNT_W'(SLOTS));
   assert_full_empty_excl_R6: assert property (@(posedge clk) disable iff (rst)
      !(full && empty));
   assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);
   assert_drop_needs_full_R7: assert property (@(posedge clk) disable iff (rst)
      !(push && full) |=> $stable(drop_cnt));
   assert_push_grows_R8: assert property (@(posedge clk) disable iff (rst)
      (push && !full && !(pop && !empty)) |=> (count_q == $past(count_q) + CNT_W'(1)));

endmodule

// File: rtl/event_unloader.sv
module event_unloader #(
   parameter int DATA_W = 16,
   parameter int WIN    = 3
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [WIN*DATA_W-1:0] head_data,
   input  logic                  q_empty,
   input  logic                  rd_ready,
   output logic                  rd_valid,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_last,
   output logic                  pop
);
   assign rd_valid = !q_empty;

   if (WIN == 1) begin : g_single
      assign rd_data = head_data;
      assign rd_last = rd_valid;
      assign pop     = rd_valid && rd_ready;
   end else begin : g_multi
      localparam int IDX_W = $clog2(WIN);
      logic [IDX_W-1:0] word_q;
      logic             at_end;

      assign at_end = (word_q == IDX_W'(WIN - 1));

      always_ff @(posedge clk) begin
         if (rst) begin
            word_q <= '0;
         end else if (rd_valid && rd_ready) begin
            word_q <= at_end ? '0 : word_q + 1'b1;
         end
      end

      assign rd_data = head_data[int'(word_q)*DATA_W +: DATA_W];
      assign rd_last = rd_valid && at_end;
      assign pop     = rd_valid && rd_ready && at_end;
   end

   assert_hold_stall_R5: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));
   assert_last_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
      rd_last |-> rd_valid);

endmodule

// File: rtl/trig_latency_derand.sv
module trig_latency_derand #(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 132,
   parameter int LATENCY = 100,
   parameter int WIN     = 3,
   parameter int SLOTS   = 8,
   parameter int DROP_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] sample_in,
   input  logic              trig_in,
   input  logic              rd_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic              q_full,
   output logic              q_empty,
   output logic              overflow,
   output logic [DROP_W-1:0] drop_count
);
   localparam int EVT_W = WIN * DATA_W;

   logic [EVT_W-1:0] window;
   logic [EVT_W-1:0] head;
   logic             pop;

   latency_ring #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .LATENCY(LATENCY),
      .WIN    (WIN)
   ) u_ring (
      .clk      (clk),
      .rst      (rst),
      .sample_in(sample_in),
      .win_data (window)
   );

   event_queue #(
      .EVT_W (EVT_W),
      .SLOTS (SLOTS),
      .DROP_W(DROP_W)
   ) u_queue (
      .clk      (clk),
      .rst      (rst),
      .push     (trig_in),
      .push_data(window),
      .pop      (pop),
      .head_data(head),
      .full     (q_full),
      .empty    (q_empty),
      .overflow (overflow),
      .drop_cnt (drop_count)
   );

   event_unloader #(
      .DATA_W(DATA_W),
      .WIN   (WIN)
   ) u_unload (
      .clk      (clk),
      .rst      (rst),
      .head_data(head),
      .q_empty  (q_empty),
      .rd_ready (rd_ready),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .rd_last  (rd_last),
      .pop      (pop)
   );

   // R7: a trigger that meets a full queue leaves it full.
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
      (trig_in && q_full && !pop) |=> q_full);

endmodule

// File: tb/test_trig_latency_derand.sv
module test_trig_latency_derand;
   localparam int DW  = 16;
   localparam int DEP = 132;
   localparam int LAT = 100;
   localparam int DRW = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic trig_in = 1'b0;
   logic rd_ready = 1'b0;
   logic [DW-1:0] xcnt;
   logic rd_valid, rd_last, q_full, q_empty, overflow;
   logic [DW-1:0] rd_data;
   logic [DRW-1:0] drop_count;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   // Crossing number since reset; it is also the sample value.
   always_ff @(posedge clk) begin
      if (rst) xcnt <= '0;
      else     xcnt <= xcnt + 1'b1;
   end

   trig_latency_derand #(
      .DATA_W(DW), .DEPTH(DEP), .LATENCY(LAT), .WIN(3), .SLOTS(8), .DROP_W(DRW)
   ) i_trig_latency_derand (
      .clk(clk), .rst(rst), .sample_in(xcnt), .trig_in(trig_in),
      .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
      .q_full(q_full), .q_empty(q_empty), .overflow(overflow), .drop_count(drop_count)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic trigger_burst(input int start, input int count);
      while (int'(xcnt) != start) @(negedge clk);
      trig_in = 1'b1;
      repeat (count) @(negedge clk);
      trig_in = 1'b0;
   endtask

   task automatic pop_word(input int exp, input bit exp_last, input string req);
      @(negedge clk);
      check(rd_valid == 1'b1, {req, " valid"}, int'(rd_valid), 1);
      check(int'(rd_data) == (exp & 16'hFFFF), {req, " data"}, int'(rd_data), exp & 16'hFFFF);
      check(rd_last == exp_last, {"R4 last flag in ", req}, int'(rd_last), int'(exp_last));
      rd_ready = 1'b1;
      @(posedge clk);
      #1 rd_ready = 1'b0;
   endtask

   task automatic drain_event(input int t, input string req);
      for (int k = 0; k < 3; k++) pop_word(t - LAT - 1 + k, k == 2, req);
   endtask

   task automatic test_reset_state();
      @(negedge clk);
      check(q_empty == 1'b1, "R1 empty", int'(q_empty), 1);
      check(q_full == 1'b0, "R1 full", int'(q_full), 0);
      check(rd_valid == 1'b0, "R1 valid", int'(rd_valid), 0);
      check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);
      check(drop_count == '0, "R1 drops", int'(drop_count), 0);
   endtask

   task automatic test_single();
      trigger_burst(150, 1);
      drain_event(150, "R3 single");
      @(negedge clk);
      check(q_empty == 1'b1, "R6 empty after drain", int'(q_empty), 1);
   endtask

   task automatic test_ring_wrap();
      // cells 131, 0, 1: window straddles the wrap point
      trigger_burst(232, 1);
      drain_event(232, "R2 wrap window");
   endtask

   task automatic test_back_to_back();
      trigger_burst(300, 2);
      drain_event(300, "R8 first of pair");
      drain_event(301, "R9 second of pair");
   endtask

   task automatic test_stall();
      trigger_burst(350, 1);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check(rd_valid == 1'b1, "R5 stalled valid", int'(rd_valid), 1);
         check(int'(rd_data) == 350 - LAT - 1, "R5 stalled data", int'(rd_data), 350 - LAT - 1);
      end
      drain_event(350, "R5 after stall");
   endtask

   task automatic test_overflow();
      trigger_burst(400, 8);
      check(q_full == 1'b1, "R6 full at 8", int'(q_full), 1);
      check(overflow == 1'b0, "R7 no overflow yet", int'(overflow), 0);
      trigger_burst(410, 1);
      check(overflow == 1'b1, "R7 overflow set", int'(overflow), 1);
      check(int'(drop_count) == 1, "R7 drop count", int'(drop_count), 1);
      check(q_full == 1'b1, "R7 still full", int'(q_full), 1);
      for (int e = 0; e < 8; e++) drain_event(400 + e, "R7 held events kept");
      @(negedge clk);
      check(q_empty == 1'b1, "R6 empty after full drain", int'(q_empty), 1);
      check(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
   endtask

   task automatic test_reset_clears();
      trigger_burst(500, 1);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      check(q_empty == 1'b1, "R1 reset empties", int'(q_empty), 1);
      check(overflow == 1'b0, "R1 reset clears overflow", int'(overflow), 0);
      check(drop_count == '0, "R1 reset clears drops", int'(drop_count), 0);
      check(rd_valid == 1'b0, "R1 reset valid", int'(rd_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      test_reset_state();
      test_single();
      test_ring_wrap();
      test_back_to_back();
      test_stall();
      test_overflow();
      test_reset_clears();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule